// File: doc/BRIEF.md
# Programmable Audio Sample-Rate Strobe Generator

This block runs on a single master audio clock and emits a one-cycle strobe at the sample rate an ADC data interface needs. Three controls set the rate. A base-length select picks an oversampling period of 256 or 384 master-clock cycles. A 4-bit rate code picks a rational scale factor that applies to that period. A pre-divide enable halves the core clock before any other division, so a 512x or 768x master clock behaves like a 256x or 384x one.

Rate codes with a numerator above one, such as 2/11 and 2/3, are built from a numerator/denominator phase accumulator. It advances once per base period and fires whenever it wraps. The strobe spacing is therefore uneven by at most one base period, while the long-run rate is exact. The halved core clock appears as a single-cycle enable, so the whole design stays in one clock domain. Codes outside the table raise a flag and give no strobe. Any change to the controls restarts every counter.

Top module: `sr_strobe_gen`

## Requirements
- R1: Rate codes 0000 and 1000 (scale 1) give one strobe every 256 cycles when `base_sel`=0 and every 384 cycles when `base_sel`=1, with `div2_en`=0.
- R2: Rate code 0010 (scale 1/6) gives one strobe every 6 base periods.
- R3: Rate code 1001 (scale 2/11) gives the k-th strobe after a restart at base period ceil(11k/2). The gaps therefore alternate between 6 and 5 base periods.
- R4: Rate code 0110 (scale 2/3) gives the k-th strobe at base period ceil(3k/2). The gaps alternate between 2 and 1 base periods.
- R5: Double-rate codes 0011 and 1011 give one strobe every half base period: 128 cycles, or 192 cycles when `base_sel`=1.
- R6: Reduced-clock codes 0111 and 1111 give one strobe every 128 or 192 cycles, selected by `base_sel`.
- R7: With `div2_en`=1, `core_en` is high on every second cycle, starting low in the first cycle after a restart, and every strobe interval doubles. With `div2_en`=0, `core_en` is constantly high.
- R8: Codes 0001, 0100, 0101, 1010, 1100 and 1101 drive `code_unsup` high in the same cycle and produce no strobe.
- R9: In a cycle where `base_sel`, `rate_code` or `div2_en` differs from its value in the previous cycle, the strobe is suppressed and all counters restart. Counting the next cycle as cycle 1, the first strobe then lands on the same cycle as it would for a fresh start.
- R10: The strobe is never high for two cycles in a row, and it is only high in cycles where `core_en` is high.
- R11: During reset, `sample_stb` is low. Counting the first cycle with reset low as cycle 1, a scale-1 setting gives its first strobe on cycle 256 (or 384, or twice those with `div2_en`=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master audio clock |
| rst | input | 1 | Synchronous active-high reset |
| base_sel | input | 1 | Base period select: 0 gives 256 cycles, 1 gives 384 cycles |
| rate_code | input | 4 | Sample-rate code choosing the scale factor |
| div2_en | input | 1 | Halve the core clock before all other division |
| sample_stb | output | 1 | One-cycle sample-rate strobe |
| core_en | output | 1 | Single-cycle enable at the (possibly halved) core clock rate |
| code_unsup | output | 1 | High while `rate_code` is not in the table |

## Verification
A change of configuration and a due strobe can fall in the same cycle. The restart must win: the strobe is dropped and the new period is counted from the following cycle. The bench provokes this by making segment lengths exact multiples of the outgoing strobe interval, so each new setting lands on a cycle where the old one would have fired. The scoreboard then rejects any strobe in that cycle and expects the next strobe at the new setting's first-period time. Accumulator settings are judged against ceil(k*den/num) base periods, which exercises the uneven 6/5 and 2/1 spacing.

// File: rtl/sr_pkg.sv
package sr_pkg;

    localparam int CODE_W = 4;
    localparam int FRAC_W = 4;

    typedef struct packed {
        logic              base_sel;
        logic [CODE_W-1:0] code;
        logic              pre_half;
    } cfg_t;

    typedef struct packed {
        logic              valid;
        logic              short_base;
        logic [FRAC_W-1:0] num;
        logic [FRAC_W-1:0] den;
    } ratio_t;

    function automatic ratio_t decode_rate(input logic [CODE_W-1:0] code);
        ratio_t r;
        r = '{valid: 1'b0, short_base: 1'b0, num: FRAC_W'(0), den: FRAC_W'(1)};
        case (code)
            4'b0000, 4'b1000: r = '{1'b1, 1'b0, FRAC_W'(1), FRAC_W'(1)};
            4'b0010:          r = '{1'b1, 1'b0, FRAC_W'(1), FRAC_W'(6)};
            4'b1001:          r = '{1'b1, 1'b0, FRAC_W'(2), FRAC_W'(11)};
            4'b0110:          r = '{1'b1, 1'b0, FRAC_W'(2), FRAC_W'(3)};
            4'b0011, 4'b1011,
            4'b0111, 4'b1111: r = '{1'b1, 1'b1, FRAC_W'(1), FRAC_W'(1)};
            default:          r = '{1'b0, 1'b0, FRAC_W'(0), FRAC_W'(1)};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sr_prediv.sv
module sr_prediv (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic half_en,
    output logic core_en
);
    logic phase_q;

    always_ff @(posedge clk) begin
        if (rst || clr) phase_q <= 1'b0;
        else if (half_en) phase_q <= ~phase_q;
        else phase_q <= 1'b0;
    end

    assign core_en = !half_en || phase_q;
endmodule

// File: rtl/sr_basecnt.sv
module sr_basecnt #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             step,
    input  logic [CNT_W-1:0] period,
    output logic             tick
);
    logic [CNT_W-1:0] cnt_q;

    assign tick = step && (cnt_q == period - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || clr)  cnt_q <= '0;
        else if (tick)   cnt_q <= '0;
        else if (step)   cnt_q <= cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/sr_ratio.sv
module sr_ratio #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         fire
);
    logic [W-1:0] acc_q;
    logic [W:0]   sum;

    assign sum  = {1'b0, acc_q} + {1'b0, num};
    assign fire = tick && (sum >= {1'b0, den});

    always_ff @(posedge clk) begin
        if (rst || clr) acc_q <= '0;
        else if (fire)  acc_q <= sum[W-1:0] - den;
        else if (tick)  acc_q <= sum[W-1:0];
    end
endmodule

// File: rtl/sr_strobe_gen.sv
module sr_strobe_gen #(
    parameter int BASE_LO = 256,
    parameter int BASE_HI = 384
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       base_sel,
    input  logic [3:0] rate_code,
    input  logic       div2_en,
    output logic       sample_stb,
    output logic       core_en,
    output logic       code_unsup
);
    import sr_pkg::*;

    localparam int CNT_W = $clog2(BASE_HI + 1);
    localparam logic [CNT_W-1:0] LEN_LO = CNT_W'(BASE_LO);
    localparam logic [CNT_W-1:0] LEN_HI = CNT_W'(BASE_HI);

    cfg_t             cfg_in, cfg_q;
    ratio_t           ratio;
    logic             cfg_chg;
    logic [CNT_W-1:0] full_len, period;
    logic             base_tick, fire;

    assign cfg_in  = '{base_sel: base_sel, code: rate_code, pre_half: div2_en};
    assign cfg_chg = (cfg_in != cfg_q);
    assign ratio   = decode_rate(cfg_in.code);

    always_ff @(posedge clk) begin
        cfg_q <= cfg_in;
    end

    assign full_len = cfg_in.base_sel ? LEN_HI : LEN_LO;
    assign period   = ratio.short_base ? (full_len >> 1) : full_len;

    sr_prediv u_prediv (
        .clk     (clk),
        .rst     (rst),
        .clr     (cfg_chg),
        .half_en (cfg_in.pre_half),
        .core_en (core_en)
    );

    sr_basecnt #(.CNT_W(CNT_W)) u_base (
        .clk    (clk),
        .rst    (rst),
        .clr    (cfg_chg),
        .step   (core_en),
        .period (period),
        .tick   (base_tick)
    );

    sr_ratio #(.W(FRAC_W)) u_ratio (
        .clk  (clk),
        .rst  (rst),
        .clr  (cfg_chg),
        .tick (base_tick),
        .num  (ratio.num),
        .den  (ratio.den),
        .fire (fire)
    );

    assign sample_stb = fire && ratio.valid && !cfg_chg && !rst;
    assign code_unsup = !ratio.valid;
endmodule

// File: rtl/sr_strobe_gen_chk.sv
module sr_strobe_gen_chk (
    input logic       clk,
    input logic       rst,
    input logic       base_sel,
    input logic [3:0] rate_code,
    input logic       div2_en,
    input logic       sample_stb,
    input logic       core_en,
    input logic       code_unsup
);
    logic [5:0] cfg_bus;
    assign cfg_bus = {base_sel, rate_code, div2_en};

    p_one_cycle_r10: assert property (@(posedge clk) disable iff (rst)
        sample_stb |=> !sample_stb);

    p_stb_on_core_r10: assert property (@(posedge clk) disable iff (rst)
        sample_stb |-> core_en);

    p_unsup_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        code_unsup |-> !sample_stb);

    p_change_drops_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_bus) |-> !sample_stb);

    p_half_alt_r7: assert property (@(posedge clk) disable iff (rst)
        (div2_en && core_en) |=> (!$stable(cfg_bus) || !core_en));

    p_full_rate_r7: assert property (@(posedge clk) disable iff (rst)
        (!div2_en && $stable(cfg_bus)) |-> core_en);
endmodule

bind sr_strobe_gen sr_strobe_gen_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .base_sel   (base_sel),
    .rate_code  (rate_code),
    .div2_en    (div2_en),
    .sample_stb (sample_stb),
    .core_en    (core_en),
    .code_unsup (code_unsup)
);

// File: tb/sim_sr_strobe_gen.sv
module sim_sr_strobe_gen;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       base_sel = 1'b0;
    logic [3:0] rate_code = 4'b0000;
    logic       div2_en = 1'b0;
    logic       sample_stb, core_en, code_unsup;

    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    bit    finished = 1'b0;
    string cur_tag = "R11";
    int    exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sr_strobe_gen u0 (
        .clk        (clk),
        .rst        (rst),
        .base_sel   (base_sel),
        .rate_code  (rate_code),
        .div2_en    (div2_en),
        .sample_stb (sample_stb),
        .core_en    (core_en),
        .code_unsup (code_unsup)
    );

    // {ok, half_period, num[3:0], den[3:0]} taken from the requirement list
    function automatic logic [9:0] tb_rate(input logic [3:0] c);
        case (c)
            4'b0000, 4'b1000: return {1'b1, 1'b0, 4'd1, 4'd1};   // R1
            4'b0010:          return {1'b1, 1'b0, 4'd1, 4'd6};   // R2
            4'b1001:          return {1'b1, 1'b0, 4'd2, 4'd11};  // R3
            4'b0110:          return {1'b1, 1'b0, 4'd2, 4'd3};   // R4
            4'b0011, 4'b1011: return {1'b1, 1'b1, 4'd1, 4'd1};   // R5
            4'b0111, 4'b1111: return {1'b1, 1'b1, 4'd1, 4'd1};   // R6
            default:          return {1'b0, 1'b0, 4'd0, 4'd1};   // R8
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Scoreboard monitor: pops expected strobe cycles
    always @(negedge clk) begin
        if (!rst && !finished) begin
            while (exp_q.size() > 0 && exp_q[0] < cyc) begin
                check(1'b0, cur_tag, -1, exp_q[0]);
                void'(exp_q.pop_front());
            end
            if (sample_stb) begin
                if (exp_q.size() > 0 && exp_q[0] == cyc) begin
                    check(1'b1, cur_tag, cyc, cyc);
                    void'(exp_q.pop_front());
                end else begin
                    check(1'b0, cur_tag, cyc, (exp_q.size() > 0) ? exp_q[0] : -1);
                end
            end
        end
    end

    // Entered at posedge+1; applies config (unless right after reset), leaves at posedge+1 of the end cycle
    task automatic run_seg(input bit sel, input logic [3:0] code, input bit half,
                           input int len, input string tag, input bit after_reset);
        logic [9:0] r;
        int c0, base, end_c, per, p, k, t;
        r = tb_rate(code);
        if (!after_reset) begin
            base_sel  = sel;
            rate_code = code;
            div2_en   = half;
        end
        c0      = cyc;
        base    = after_reset ? c0 - 1 : c0;
        end_c   = c0 + len;
        cur_tag = tag;
        per = sel ? 384 : 256;
        if (r[8]) per = per / 2;
        p = half ? 2 : 1;
        if (r[9]) begin
            k = 1;
            forever begin
                t = base + p * per * ((k * int'(r[3:0]) + int'(r[7:4]) - 1) / int'(r[7:4]));
                if (t >= end_c) break;
                exp_q.push_back(t);
                k++;
            end
        end
        @(negedge clk);
        check(code_unsup == !r[9], "R8", code_unsup, !r[9]);
        if (!after_reset) begin
            logic [3:0] pat;
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                pat[3-i] = core_en;
            end
            check(pat == (half ? 4'b0101 : 4'b1111), "R7", pat, half ? 4'b0101 : 4'b1111);
        end
        do begin
            @(posedge clk);
            #1;
        end while (cyc < end_c);
        check(exp_q.size() == 0, tag, exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(sample_stb == 1'b0, "R11", sample_stb, 0);
        @(posedge clk);
        #1;
        rst = 1'b0;
        run_seg(1'b0, 4'b0000, 1'b0, 512,            "R11", 1'b1);
        // ends on a due strobe: change in that cycle must drop it (R9)
        run_seg(1'b1, 4'b1000, 1'b0, 768,            "R1",  1'b0);
        run_seg(1'b0, 4'b0010, 1'b0, 3072,           "R2",  1'b0);
        run_seg(1'b1, 4'b1001, 1'b0, 384 * 17,       "R3",  1'b0);
        run_seg(1'b0, 4'b0110, 1'b0, 256 * 6,        "R4",  1'b0);
        run_seg(1'b0, 4'b0011, 1'b0, 128 * 3,        "R5",  1'b0);
        run_seg(1'b1, 4'b1011, 1'b0, 192 * 3 + 5,    "R5",  1'b0);
        run_seg(1'b0, 4'b0111, 1'b0, 128 * 3,        "R6",  1'b0);
        run_seg(1'b1, 4'b1111, 1'b0, 192 * 3 + 5,    "R6",  1'b0);
        run_seg(1'b0, 4'b0101, 1'b0, 900,            "R8",  1'b0);
        run_seg(1'b0, 4'b0000, 1'b1, 512 * 2,        "R7",  1'b0);
        run_seg(1'b1, 4'b0111, 1'b1, 384 * 2 + 5,    "R7",  1'b0);
        run_seg(1'b1, 4'b1100, 1'b0, 900,            "R8",  1'b0);
        // mid-period change: restart measured from change (R9)
        run_seg(1'b0, 4'b0000, 1'b0, 100,            "R9",  1'b0);
        run_seg(1'b0, 4'b1000, 1'b0, 600,            "R9",  1'b0);
        run_seg(1'b0, 4'b0110, 1'b1, 512 * 3,        "R10", 1'b0);
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule